// File: doc/BRIEF.md
# Region-of-Interest Read-out Sequencer

This block walks an image sensor frame of 1280 columns by 1024 rows row by row and keeps the output inside a rectangular window. For every row in the window it runs three phases in turn: a row-select strobe, a strobe that latches the digitized row into the converter register, and a strobe that moves it to the output register. It then steps a column counter across the window one group of ten pixels per clock and raises an in-window valid flag on each step. After the last column of the last window row it gives a one-cycle frame-done pulse.

Four window bounds come in as plain inputs: first column group, last column group, first row and last row. The block samples them on a start pulse from the exposure controller, so a host can rewrite them while a frame is being read. Each bound is inclusive and each axis is independent. A window can therefore be a single group on a single row, or the whole frame, and it can sit anywhere. The pixel data path and the programming interface that drives the bound inputs are outside this block.

Top module: `roi_readout_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, all three row-phase strobes, colValid and frameDone are low.
- R2: A one-cycle startPulse while idle starts a frame. In the next cycle rowSelStb is high and rowAddr equals the sampled first row.
- R3: Each window row runs rowSelStb, adcLatchStb and xferStb in consecutive cycles, one cycle each, and then its column walk. rowAddr holds its value from the row-select cycle through the end of that row's walk.
- R4: The column walk sets colIdx to every group index from the first to the last column bound inclusive, ascending, one per cycle, and colValid is high exactly in those cycles. One group equals 10 pixels, so there are 128 groups, indices 0 to 127.
- R5: Rows are visited from the first to the last row bound inclusive, ascending by one, one row-select per row.
- R6: When a last bound is smaller than its first bound on the same axis, the last bound is taken to equal the first bound.
- R7: The bounds are sampled only when a frame starts. Changes to them during a frame do not affect that frame and apply from the next start.
- R8: A startPulse that arrives while busy is high is ignored. It does not restart or extend the frame, and no new frame follows.
- R9: frameDone is high for exactly one cycle, the cycle right after the last colValid of the frame. busy is low from the following cycle on. A window of W groups and H rows takes H*(3+W) cycles from the first row-select to frameDone.
- R10: The full-frame window (groups 0 to 127, rows 0 to 1023) and single-group windows at the far corner of the frame are sequenced correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle frame start request from the exposure controller |
| colFirstIn | input | 7 | First column group of the window (inclusive) |
| colLastIn | input | 7 | Last column group of the window (inclusive) |
| rowFirstIn | input | 10 | First row of the window (inclusive) |
| rowLastIn | input | 10 | Last row of the window (inclusive) |
| rowAddr | output | 10 | Current row address |
| rowSelStb | output | 1 | Row-select phase strobe |
| adcLatchStb | output | 1 | Converter-register latch phase strobe |
| xferStb | output | 1 | Transfer-to-output-register phase strobe |
| colIdx | output | 7 | Current column group index |
| colValid | output | 1 | High while colIdx lies inside the window |
| frameDone | output | 1 | One-cycle pulse after the last window pixel group |
| busy | output | 1 | High from frame start until frameDone |

## Verification
A corrupted column or row counter shows at colIdx or rowAddr on the very next colValid or rowSelStb cycle. An off-by-one in a bound comparison changes the colValid count of every row and moves frameDone by whole cycles. A phase controller that skips or repeats a phase breaks the fixed three-strobe pattern within one row. Bounds latched at the wrong moment show up as coordinates that follow the mid-frame input values and not the sampled ones, starting from the first walk cycle after the change.

// File: rtl/roi_pkg.sv
package roi_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROWSEL,
    PH_ADCLATCH,
    PH_XFER,
    PH_COLWALK,
    PH_DONE
  } roiPhase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadWin;   // sample bounds, preset row counter
    logic rowStep;   // advance to next row
    logic colInit;   // preset column counter to first group
    logic colStep;   // advance column counter
  } roiStrobes_t;

endpackage

// File: rtl/roi_datapath.sv
module roi_datapath
  import roi_pkg::*;
#(
  parameter int COL_W = 7,
  parameter int ROW_W = 10,
  parameter int COL_MAX = 127,
  parameter int ROW_MAX = 1023
) (
  input  logic             clk,
  input  logic             rstN,
  input  roiStrobes_t      strb,
  input  logic [COL_W-1:0] colFirstIn,
  input  logic [COL_W-1:0] colLastIn,
  input  logic [ROW_W-1:0] rowFirstIn,
  input  logic [ROW_W-1:0] rowLastIn,
  output logic [ROW_W-1:0] rowCnt,
  output logic [COL_W-1:0] colCnt,
  output logic             colAtEnd,
  output logic             rowAtEnd,
  output logic [COL_W-1:0] winColFirst,
  output logic [COL_W-1:0] winColLast,
  output logic [ROW_W-1:0] winRowFirst,
  output logic [ROW_W-1:0] winRowLast
);

  localparam logic [COL_W-1:0] ColTop = COL_W'(COL_MAX);
  localparam logic [ROW_W-1:0] RowTop = ROW_W'(ROW_MAX);

  logic [COL_W-1:0] colFirstLim, colLastLim, colLastEff;
  logic [ROW_W-1:0] rowFirstLim, rowLastLim, rowLastEff;

  // limit to the frame, then force last >= first
  always_comb begin
    colFirstLim = (colFirstIn > ColTop) ? ColTop : colFirstIn;
    colLastLim  = (colLastIn  > ColTop) ? ColTop : colLastIn;
    rowFirstLim = (rowFirstIn > RowTop) ? RowTop : rowFirstIn;
    rowLastLim  = (rowLastIn  > RowTop) ? RowTop : rowLastIn;
    colLastEff  = (colLastLim < colFirstLim) ? colFirstLim : colLastLim;
    rowLastEff  = (rowLastLim < rowFirstLim) ? rowFirstLim : rowLastLim;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winColFirst <= '0;
      winColLast  <= '0;
      winRowFirst <= '0;
      winRowLast  <= '0;
    end else if (strb.loadWin) begin
      winColFirst <= colFirstLim;
      winColLast  <= colLastEff;
      winRowFirst <= rowFirstLim;
      winRowLast  <= rowLastEff;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCnt <= '0;
    end else if (strb.loadWin) begin
      rowCnt <= rowFirstLim;
    end else if (strb.rowStep) begin
      rowCnt <= rowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
    end else if (strb.colInit) begin
      colCnt <= winColFirst;
    end else if (strb.colStep) begin
      colCnt <= colCnt + 1'b1;
    end
  end

  assign colAtEnd = (colCnt == winColLast);
  assign rowAtEnd = (rowCnt == winRowLast);

  // R6: sampled window is never inverted
  assert_win_ordered_R6: assert property (@(posedge clk) disable iff (!rstN)
    (winColLast >= winColFirst) && (winRowLast >= winRowFirst));

  // R5: a row step never runs past the sampled last row
  assert_row_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.rowStep |=> (rowCnt <= winRowLast) && (rowCnt > winRowFirst));

endmodule

// File: rtl/roi_ctrl.sv
module roi_ctrl
  import roi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        colAtEnd,
  input  logic        rowAtEnd,
  output roiStrobes_t strb,
  output logic        rowSelStb,
  output logic        adcLatchStb,
  output logic        xferStb,
  output logic        colValid,
  output logic        frameDone,
  output logic        busy
);

  roiPhase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:     if (startPulse) phaseNext = PH_ROWSEL;
      PH_ROWSEL:   phaseNext = PH_ADCLATCH;
      PH_ADCLATCH: phaseNext = PH_XFER;
      PH_XFER:     phaseNext = PH_COLWALK;
      PH_COLWALK:  if (colAtEnd) phaseNext = rowAtEnd ? PH_DONE : PH_ROWSEL;
      PH_DONE:     phaseNext = PH_IDLE;
      default:     phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strb.loadWin = (phase == PH_IDLE) && startPulse;
    strb.colInit = (phase == PH_XFER);
    strb.colStep = (phase == PH_COLWALK) && !colAtEnd;
    strb.rowStep = (phase == PH_COLWALK) && colAtEnd && !rowAtEnd;
  end

  assign rowSelStb   = (phase == PH_ROWSEL);
  assign adcLatchStb = (phase == PH_ADCLATCH);
  assign xferStb     = (phase == PH_XFER);
  assign colValid    = (phase == PH_COLWALK);
  assign frameDone   = (phase == PH_DONE);
  assign busy        = (phase != PH_IDLE);

  // R3: fixed phase order within a row
  assert_sel_then_adc_R3: assert property (@(posedge clk) disable iff (!rstN)
    rowSelStb |=> adcLatchStb);
  assert_adc_then_xfer_R3: assert property (@(posedge clk) disable iff (!rstN)
    adcLatchStb |=> xferStb);
  assert_xfer_then_walk_R3: assert property (@(posedge clk) disable iff (!rstN)
    xferStb |=> colValid);

  // R9: done is a single pulse ending the frame
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone && !busy);
  assert_done_after_walk_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(colValid));

endmodule

// File: rtl/roi_readout_seq.sv
module roi_readout_seq
  import roi_pkg::*;
#(
  parameter int SENSOR_COLS = 1280,
  parameter int SENSOR_ROWS = 1024,
  parameter int GROUP_PIX   = 10
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     startPulse,
  input  logic [$clog2(SENSOR_COLS/GROUP_PIX)-1:0] colFirstIn,
  input  logic [$clog2(SENSOR_COLS/GROUP_PIX)-1:0] colLastIn,
  input  logic [$clog2(SENSOR_ROWS)-1:0]           rowFirstIn,
  input  logic [$clog2(SENSOR_ROWS)-1:0]           rowLastIn,
  output logic [$clog2(SENSOR_ROWS)-1:0]           rowAddr,
  output logic                                     rowSelStb,
  output logic                                     adcLatchStb,
  output logic                                     xferStb,
  output logic [$clog2(SENSOR_COLS/GROUP_PIX)-1:0] colIdx,
  output logic                                     colValid,
  output logic                                     frameDone,
  output logic                                     busy
);

  localparam int GROUPS = SENSOR_COLS / GROUP_PIX;
  localparam int COL_W  = $clog2(GROUPS);
  localparam int ROW_W  = $clog2(SENSOR_ROWS);

  roiStrobes_t      strb;
  logic             colAtEnd, rowAtEnd;
  logic [COL_W-1:0] winColFirst, winColLast;
  logic [ROW_W-1:0] winRowFirst, winRowLast;

  roi_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .colAtEnd    (colAtEnd),
    .rowAtEnd    (rowAtEnd),
    .strb        (strb),
    .rowSelStb   (rowSelStb),
    .adcLatchStb (adcLatchStb),
    .xferStb     (xferStb),
    .colValid    (colValid),
    .frameDone   (frameDone),
    .busy        (busy)
  );

  roi_datapath #(
    .COL_W   (COL_W),
    .ROW_W   (ROW_W),
    .COL_MAX (GROUPS - 1),
    .ROW_MAX (SENSOR_ROWS - 1)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .colFirstIn  (colFirstIn),
    .colLastIn   (colLastIn),
    .rowFirstIn  (rowFirstIn),
    .rowLastIn   (rowLastIn),
    .rowCnt      (rowAddr),
    .colCnt      (colIdx),
    .colAtEnd    (colAtEnd),
    .rowAtEnd    (rowAtEnd),
    .winColFirst (winColFirst),
    .winColLast  (winColLast),
    .winRowFirst (winRowFirst),
    .winRowLast  (winRowLast)
  );

  // R4: walk stays inside the sampled window and steps by one
  assert_col_in_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    colValid |-> (colIdx >= winColFirst) && (colIdx <= winColLast));
  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    colValid && $past(colValid) |-> colIdx == COL_W'($past(colIdx) + 1'b1));

  // R3: row address held through the row's later phases
  assert_row_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (adcLatchStb || xferStb || colValid) |-> $stable(rowAddr));

  // R7/R8: bounds frozen while a frame is running
  assert_win_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable({winColFirst, winColLast, winRowFirst, winRowLast}));

  // R2: first row-select uses the sampled first row
  assert_first_row_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> rowSelStb && (rowAddr == winRowFirst));

endmodule

// File: tb/test_roi_readout_seq.sv
module test_roi_readout_seq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [6:0] colFirstIn = '0, colLastIn = '0;
  logic [9:0] rowFirstIn = '0, rowLastIn = '0;
  logic [9:0] rowAddr;
  logic [6:0] colIdx;
  logic       rowSelStb, adcLatchStb, xferStb, colValid, frameDone, busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  roi_readout_seq i_roi_readout_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .colFirstIn(colFirstIn), .colLastIn(colLastIn),
    .rowFirstIn(rowFirstIn), .rowLastIn(rowLastIn),
    .rowAddr(rowAddr), .rowSelStb(rowSelStb), .adcLatchStb(adcLatchStb),
    .xferStb(xferStb), .colIdx(colIdx), .colValid(colValid),
    .frameDone(frameDone), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one frame and checks it against bounds computed here.
  // changeAt: cycle at which bound inputs are rewritten (-1 none)
  // pokeAt: cycle at which a start pulse is sent mid-frame (-1 none)
  task automatic run_frame(input int hs, input int he, input int vs, input int ve,
                           input int changeAt, input int pokeAt, input string tag);
    int ehe, eve, w, rows, cnt, expRow, expCol, nValid, nSel;
    int seqErr, coordErr, prevPh, ph, limit;
    bit done;
    ehe = (he < hs) ? hs : he;
    eve = (ve < vs) ? vs : ve;
    w = ehe - hs + 1;
    rows = eve - vs + 1;
    limit = rows * (3 + w) + 20;
    @(negedge clk);
    colFirstIn = 7'(hs); colLastIn = 7'(he);
    rowFirstIn = 10'(vs); rowLastIn = 10'(ve);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    cnt = 0; expRow = vs; expCol = hs; nValid = 0; nSel = 0;
    seqErr = 0; coordErr = 0; prevPh = 4; done = 0;
    while (!done && cnt < limit) begin
      ph = 0;
      if ((int'(rowSelStb) + int'(adcLatchStb) + int'(xferStb) + int'(colValid) + int'(frameDone)) > 1)
        seqErr++;
      if (rowSelStb) ph = 1;
      else if (adcLatchStb) ph = 2;
      else if (xferStb) ph = 3;
      else if (colValid) ph = 4;
      else if (frameDone) ph = 5;
      case (ph)
        1: if (prevPh != 4) seqErr++;
        2: if (prevPh != 1) seqErr++;
        3: if (prevPh != 2) seqErr++;
        4: if (prevPh != 3 && prevPh != 4) seqErr++;
        5: if (prevPh != 4) seqErr++;
        default: seqErr++;
      endcase
      if (cnt == 0 && ph != 1) seqErr++;
      if (ph == 1) begin
        nSel++;
        if (int'(rowAddr) != expRow) coordErr++;
      end
      if (ph == 4) begin
        nValid++;
        if (int'(rowAddr) != expRow || int'(colIdx) != expCol) coordErr++;
        expCol++;
        if (expCol > ehe) begin
          expCol = hs;
          expRow++;
        end
      end
      prevPh = ph;
      if (frameDone) begin
        done = 1;
      end else begin
        @(negedge clk);
        startPulse = 1'b0;
        cnt++;
        if (cnt == changeAt) begin
          colFirstIn = 7'd1; colLastIn = 7'd2;
          rowFirstIn = 10'd900; rowLastIn = 10'd901;
        end
        if (cnt == pokeAt) startPulse = 1'b1;
      end
    end
    chk(done, "R9", {tag, " frameDone seen"}, int'(done), 1);
    chk(cnt == rows * (3 + w), "R9", {tag, " cycles to frameDone"}, cnt, rows * (3 + w));
    chk(nValid == rows * w, "R4", {tag, " colValid count"}, nValid, rows * w);
    chk(nSel == rows, "R5", {tag, " row-select count"}, nSel, rows);
    chk(seqErr == 0, "R3", {tag, " phase order errors"}, seqErr, 0);
    chk(coordErr == 0, "R4", {tag, " coordinate errors (R5 rows)"}, coordErr, 0);
    @(negedge clk);
    chk(!frameDone && !busy, "R9", {tag, " done/busy after pulse"},
        int'({frameDone, busy}), 0);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, rowSelStb, adcLatchStb, xferStb, colValid, frameDone} == 6'b0,
        "R1", "outputs in reset", int'({busy, rowSelStb, adcLatchStb, xferStb, colValid, frameDone}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, rowSelStb, colValid, frameDone} == 4'b0, "R1", "outputs after reset",
        int'({busy, rowSelStb, colValid, frameDone}), 0);
  endtask

  task automatic t_start_row();
    @(negedge clk);
    colFirstIn = 7'd20; colLastIn = 7'd21;
    rowFirstIn = 10'd333; rowLastIn = 10'd333;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(rowSelStb && busy, "R2", "row-select after start", int'(rowSelStb), 1);
    chk(rowAddr == 10'd333, "R2", "first rowAddr", int'(rowAddr), 333);
    while (busy) @(negedge clk);
  endtask

  task automatic t_small();   run_frame(5, 8, 100, 102, -1, -1, "small R4 R5"); endtask
  task automatic t_single();  run_frame(60, 60, 512, 512, -1, -1, "single R10"); endtask
  task automatic t_clamp();   run_frame(10, 3, 40, 37, -1, -1, "clamp R6"); endtask
  task automatic t_corner();  run_frame(127, 127, 1023, 1023, -1, -1, "corner R10"); endtask
  task automatic t_origin();  run_frame(0, 2, 0, 1, -1, -1, "origin R4"); endtask

  task automatic t_mid_change();
    run_frame(30, 33, 200, 203, 5, -1, "midchange R7");
    // inputs now hold 1..2 / 900..901: next frame must follow them
    run_frame(1, 2, 900, 901, -1, -1, "nextframe R7");
  endtask

  task automatic t_busy_start();
    int extra;
    run_frame(7, 9, 10, 12, -1, 6, "busystart R8");
    extra = 0;
    repeat (8) begin
      @(negedge clk);
      if (busy || rowSelStb) extra++;
    end
    chk(extra == 0, "R8", "no frame after ignored start", extra, 0);
  endtask

  task automatic t_full();    run_frame(0, 127, 0, 1023, -1, -1, "full R10"); endtask

  initial begin
    t_reset();
    t_start_row();
    t_small();
    t_single();
    t_clamp();
    t_corner();
    t_origin();
    t_mid_change();
    t_busy_start();
    t_full();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule